// File: doc/BRIEF.md
# Receiver Command-Strobe State Sequencer

This block turns single-cycle command strobes, already decoded from the serial host port, into the operating state of a radio receiver. It keeps the receiver in one of six states: power-down, oscillator-off, idle, synthesizer calibration, receive, and receive-FIFO overflow. From that state it drives the oscillator enable and the receiver enable. It also issues one-cycle pulses that start a calibration, flush the receive FIFO, or return the register file to its defaults. The state is exported as a 3-bit code for the host status byte.

Some strobes take effect only in certain states. Others are deferred. A power-down request is held until the chip select goes high. A FIFO flush is honoured only while idle or in overflow. Calibration is a handshake: the block pulses a start output and waits for a done input. It then settles in idle after a standalone calibration, or in receive when the calibration was triggered by the receive strobe with auto-calibration enabled.

Each strobe is a 6-bit address in the range 0x30 to 0x3D, qualified by `strobe_valid`. State codes are power-down 0, oscillator-off 1, idle 2, calibration 3, receive 4, overflow 5. All outputs are registered and change on the clock edge that samples the causing input.

Top module: `rx_strobe_sequencer`

## Requirements
- R1: While reset is held and right after it is released, `state_code` is 2 (idle), `xosc_en` is 1, and `rx_en`, `cal_start`, `fifo_flush` and `reg_reset` are 0.
- R2: The no-operation strobe 0x3D and the reserved codes 0x31, 0x35, 0x37, 0x38, 0x3B and 0x3C change no state and raise no pulse.
- R3: Strobe 0x30 moves any state to idle (2), cancels a pending power-down, and raises `reg_reset` for exactly one cycle.
- R4: Strobe 0x32 in idle moves to oscillator-off (1) with `xosc_en` low.
- R5: Strobe 0x33 in idle moves to calibration (3) with a one-cycle `cal_start` pulse. `cal_done` then returns the block to idle (2).
- R6: Strobe 0x34 in idle with `autocal_en` low moves straight to receive (4) with `rx_en` high.
- R7: Strobe 0x34 in idle with `autocal_en` high moves to calibration (3) with a `cal_start` pulse. `cal_done` then moves to receive (4).
- R8: Strobe 0x36 moves calibration, receive or overflow to idle. Issued in idle, it cancels a pending power-down.
- R9: Strobe 0x39 in idle leaves the state unchanged. The first later rise of `cs_n` moves to power-down (0) with `xosc_en` low.
- R10: Strobe 0x3A in idle or overflow raises `fifo_flush` for one cycle and leaves the block in idle. In other states it raises no pulse.
- R11: `fifo_ovf` in receive moves to overflow (5) with `rx_en` low. Overflow holds until strobe 0x3A, 0x36 or 0x30.
- R12: In power-down or oscillator-off, a fall of `cs_n` returns to idle. Every strobe except 0x30 is ignored there.
- R13: A strobe that is defined but not permitted in the current state is ignored, for example 0x33 or 0x34 in receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_valid | input | 1 | Qualifies `strobe_addr` for one cycle |
| strobe_addr | input | 6 | Command strobe address, 0x30 to 0x3D |
| cs_n | input | 1 | Host chip select, active low |
| autocal_en | input | 1 | Calibrate before receive |
| cal_done | input | 1 | Calibration finished |
| fifo_ovf | input | 1 | Receive FIFO overflowed |
| state_code | output | 3 | Current state code for the status byte |
| xosc_en | output | 1 | Crystal oscillator enable |
| rx_en | output | 1 | Receiver enable |
| cal_start | output | 1 | One-cycle calibration start pulse |
| fifo_flush | output | 1 | One-cycle receive FIFO flush pulse |
| reg_reset | output | 1 | One-cycle register-default pulse |

## Verification
The assertions assume that a strobe arrives only while `cs_n` is low, is never repeated back-to-back as a held level, and never coincides with a `cs_n` edge. Under that assumption a power-down can only start on a rise that follows an idle cycle, and a no-operation strobe sees no chip-select edge. The random stimulus keeps to this. It raises `strobe_valid` only in cycles where `cs_n` stays low and unchanged, and uses any cycle that toggles `cs_n` for nothing else. `cal_done` and `fifo_ovf` are driven freely, since the block must ignore them outside calibration and receive.

// File: rtl/rss_pkg.sv
`timescale 1ns/1ps
package rss_pkg;

    localparam int STROBE_W = 6;
    localparam int STATE_W  = 3;

    // Strobe addresses; the host port decodes these values.
    localparam logic [STROBE_W-1:0] SA_RESET = 6'h30;
    localparam logic [STROBE_W-1:0] SA_XOFF  = 6'h32;
    localparam logic [STROBE_W-1:0] SA_CAL   = 6'h33;
    localparam logic [STROBE_W-1:0] SA_RX    = 6'h34;
    localparam logic [STROBE_W-1:0] SA_IDLE  = 6'h36;
    localparam logic [STROBE_W-1:0] SA_PWD   = 6'h39;
    localparam logic [STROBE_W-1:0] SA_FLUSH = 6'h3A;
    localparam logic [STROBE_W-1:0] SA_NOP   = 6'h3D;

    // State encoding is exported in the status byte.
    typedef enum logic [STATE_W-1:0] {
        ST_PWRDN = 3'd0,
        ST_XOFF  = 3'd1,
        ST_IDLE  = 3'd2,
        ST_CAL   = 3'd3,
        ST_RX    = 3'd4,
        ST_OVF   = 3'd5
    } rss_state_e;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_XOFF,
        CMD_CAL,
        CMD_RX,
        CMD_IDLE,
        CMD_PWD,
        CMD_FLUSH,
        CMD_NOP
    } rss_cmd_e;

endpackage

// File: rtl/rss_strobe_decode.sv
`timescale 1ns/1ps
module rss_strobe_decode
    import rss_pkg::*;
(
    input  logic                strobe_valid,
    input  logic [STROBE_W-1:0] strobe_addr,
    output rss_cmd_e            cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (strobe_valid) begin
            case (strobe_addr)
                SA_RESET: cmd = CMD_RESET;
                SA_XOFF:  cmd = CMD_XOFF;
                SA_CAL:   cmd = CMD_CAL;
                SA_RX:    cmd = CMD_RX;
                SA_IDLE:  cmd = CMD_IDLE;
                SA_PWD:   cmd = CMD_PWD;
                SA_FLUSH: cmd = CMD_FLUSH;
                SA_NOP:   cmd = CMD_NOP;
                default:  cmd = CMD_NONE;   // reserved or out of range
            endcase
        end
    end

endmodule

// File: rtl/rss_csn_edge.sv
`timescale 1ns/1ps
module rss_csn_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic csn_rise,
    output logic csn_fall
);

    logic cs_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_n_q <= 1'b1;
        else        cs_n_q <= cs_n;
    end

    assign csn_rise =  cs_n && !cs_n_q;
    assign csn_fall = !cs_n &&  cs_n_q;

endmodule

// File: rtl/rss_fsm.sv
`timescale 1ns/1ps
module rss_fsm
    import rss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rss_cmd_e   cmd,
    input  logic       csn_rise,
    input  logic       csn_fall,
    input  logic       autocal_en,
    input  logic       cal_done,
    input  logic       fifo_ovf,
    output rss_state_e state,
    output logic       xosc_en,
    output logic       rx_en,
    output logic       cal_start,
    output logic       fifo_flush,
    output logic       reg_reset
);

    rss_state_e nxt_state;
    logic       pend_pwd,  nxt_pend;
    logic       cal_to_rx, nxt_cal_to_rx;
    logic       req_cal, req_flush, req_reset;

    // Next-state and pulse requests
    always_comb begin
        nxt_state     = state;
        nxt_pend      = pend_pwd;
        nxt_cal_to_rx = cal_to_rx;
        req_cal       = 1'b0;
        req_flush     = 1'b0;
        req_reset     = 1'b0;

        if (cmd == CMD_RESET) begin
            nxt_state     = ST_IDLE;
            nxt_pend      = 1'b0;
            nxt_cal_to_rx = 1'b0;
            req_reset     = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    case (cmd)
                        CMD_XOFF: nxt_state = ST_XOFF;
                        CMD_CAL: begin
                            nxt_state     = ST_CAL;
                            nxt_cal_to_rx = 1'b0;
                            req_cal       = 1'b1;
                        end
                        CMD_RX: begin
                            if (autocal_en) begin
                                nxt_state     = ST_CAL;
                                nxt_cal_to_rx = 1'b1;
                                req_cal       = 1'b1;
                            end else begin
                                nxt_state = ST_RX;
                            end
                        end
                        CMD_IDLE:  nxt_pend  = 1'b0;
                        CMD_PWD:   nxt_pend  = 1'b1;
                        CMD_FLUSH: req_flush = 1'b1;
                        default: begin
                            if (pend_pwd && csn_rise) nxt_state = ST_PWRDN;
                        end
                    endcase
                end
                ST_CAL: begin
                    if (cmd == CMD_IDLE)  nxt_state = ST_IDLE;
                    else if (cal_done)    nxt_state = cal_to_rx ? ST_RX : ST_IDLE;
                end
                ST_RX: begin
                    if (cmd == CMD_IDLE)  nxt_state = ST_IDLE;
                    else if (fifo_ovf)    nxt_state = ST_OVF;
                end
                ST_OVF: begin
                    if (cmd == CMD_FLUSH) begin
                        nxt_state = ST_IDLE;
                        req_flush = 1'b1;
                    end else if (cmd == CMD_IDLE) begin
                        nxt_state = ST_IDLE;
                    end
                end
                ST_XOFF, ST_PWRDN: begin
                    if (csn_fall) nxt_state = ST_IDLE;
                end
                default: nxt_state = ST_IDLE;
            endcase
        end

        if (nxt_state != ST_IDLE) nxt_pend = 1'b0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_pwd  <= 1'b0;
            cal_to_rx <= 1'b0;
        end else begin
            state     <= nxt_state;
            pend_pwd  <= nxt_pend;
            cal_to_rx <= nxt_cal_to_rx;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xosc_en    <= 1'b1;
            rx_en      <= 1'b0;
            cal_start  <= 1'b0;
            fifo_flush <= 1'b0;
            reg_reset  <= 1'b0;
        end else begin
            xosc_en    <= !((nxt_state == ST_PWRDN) || (nxt_state == ST_XOFF));
            rx_en      <= (nxt_state == ST_RX);
            cal_start  <= req_cal;
            fifo_flush <= req_flush;
            reg_reset  <= req_reset;
        end
    end

endmodule

// File: rtl/rx_strobe_sequencer.sv
`timescale 1ns/1ps
module rx_strobe_sequencer
    import rss_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_valid,
    input  logic [STROBE_W-1:0] strobe_addr,
    input  logic                cs_n,
    input  logic                autocal_en,
    input  logic                cal_done,
    input  logic                fifo_ovf,
    output logic [STATE_W-1:0]  state_code,
    output logic                xosc_en,
    output logic                rx_en,
    output logic                cal_start,
    output logic                fifo_flush,
    output logic                reg_reset
);

    rss_cmd_e   cmd;
    rss_state_e state;
    logic       csn_rise, csn_fall;

    rss_strobe_decode dec_i (
        .strobe_valid (strobe_valid),
        .strobe_addr  (strobe_addr),
        .cmd          (cmd)
    );

    rss_csn_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .csn_rise (csn_rise),
        .csn_fall (csn_fall)
    );

    rss_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .csn_rise   (csn_rise),
        .csn_fall   (csn_fall),
        .autocal_en (autocal_en),
        .cal_done   (cal_done),
        .fifo_ovf   (fifo_ovf),
        .state      (state),
        .xosc_en    (xosc_en),
        .rx_en      (rx_en),
        .cal_start  (cal_start),
        .fifo_flush (fifo_flush),
        .reg_reset  (reg_reset)
    );

    assign state_code = state;

endmodule

// File: rtl/rss_checker.sv
`timescale 1ns/1ps
module rss_checker
    import rss_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                strobe_valid,
    input logic [STROBE_W-1:0] strobe_addr,
    input logic                cs_n,
    input logic                cal_done,
    input logic                fifo_ovf,
    input logic [STATE_W-1:0]  state_code,
    input logic                xosc_en,
    input logic                rx_en,
    input logic                cal_start,
    input logic                fifo_flush,
    input logic                reg_reset
);

    // R4 R9 R12
    xosc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xosc_en == !((state_code == 3'd0) || (state_code == 3'd1)));

    // R6
    rx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en == (state_code == 3'd4));

    // R5
    cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> (state_code == 3'd3) && ($past(state_code) == 3'd2));

    // R5
    cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R7
    cal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_code) == 3'd3) && (state_code == 3'd4)) |-> $past(cal_done));

    // R10
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> (state_code == 3'd2));

    // R3
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_reset |-> (state_code == 3'd2));

    // R11
    ovf_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 3'd5) && ($past(state_code) != 3'd5)) |->
            (($past(state_code) == 3'd4) && $past(fifo_ovf)));

    // R9
    pwrdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_code == 3'd0) && ($past(state_code) != 3'd0)) |->
            (($past(state_code) == 3'd2) && $past(cs_n)));

    // R2
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_valid && (strobe_addr == SA_NOP) && !cal_done && !fifo_ovf
            && (cs_n == $past(cs_n)))
            |=> (state_code == $past(state_code)) && !cal_start && !fifo_flush && !reg_reset);

endmodule

bind rx_strobe_sequencer rss_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_valid (strobe_valid),
    .strobe_addr  (strobe_addr),
    .cs_n         (cs_n),
    .cal_done     (cal_done),
    .fifo_ovf     (fifo_ovf),
    .state_code   (state_code),
    .xosc_en      (xosc_en),
    .rx_en        (rx_en),
    .cal_start    (cal_start),
    .fifo_flush   (fifo_flush),
    .reg_reset    (reg_reset)
);

// File: tb/rx_strobe_sequencer_tb_top.sv
`timescale 1ns/1ps
module rx_strobe_sequencer_tb_top;

    localparam logic [2:0] E_PWRDN = 3'd0, E_XOFF = 3'd1, E_IDLE = 3'd2,
                           E_CAL = 3'd3, E_RX = 3'd4, E_OVF = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_valid = 1'b0;
    logic [5:0] strobe_addr = 6'h3D;
    logic       cs_n = 1'b1;
    logic       autocal_en = 1'b0;
    logic       cal_done = 1'b0;
    logic       fifo_ovf = 1'b0;
    logic [2:0] state_code;
    logic       xosc_en, rx_en, cal_start, fifo_flush, reg_reset;

    int vectors = 0;
    int miscompares = 0;

    // Reference model state
    logic [2:0] m_st   = E_IDLE;
    logic       m_pend = 1'b0;
    logic       m_ret  = 1'b0;
    logic       m_csq  = 1'b1;

    typedef struct packed {
        logic [2:0] st;
        logic       pend;
        logic       ret;
        logic       calp;
        logic       flushp;
        logic       resp;
    } model_t;

    always #2 clk = ~clk;

    rx_strobe_sequencer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_valid (strobe_valid),
        .strobe_addr  (strobe_addr),
        .cs_n         (cs_n),
        .autocal_en   (autocal_en),
        .cal_done     (cal_done),
        .fifo_ovf     (fifo_ovf),
        .state_code   (state_code),
        .xosc_en      (xosc_en),
        .rx_en        (rx_en),
        .cal_start    (cal_start),
        .fifo_flush   (fifo_flush),
        .reg_reset    (reg_reset)
    );

    function automatic model_t model_next(
        input logic [2:0] st, input logic pend, input logic ret, input logic csq,
        input logic v, input logic [5:0] a, input logic ac, input logic cd,
        input logic ov, input logic cs);
        model_t r;
        logic rise, fall;
        rise = cs && !csq;
        fall = !cs && csq;
        r = '{st: st, pend: pend, ret: ret, calp: 1'b0, flushp: 1'b0, resp: 1'b0};
        if (v && a == 6'h30) begin
            r.st = E_IDLE; r.pend = 1'b0; r.ret = 1'b0; r.resp = 1'b1;
        end else begin
            case (st)
                E_IDLE: begin
                    if (v && a == 6'h32) r.st = E_XOFF;
                    else if (v && a == 6'h33) begin r.st = E_CAL; r.ret = 1'b0; r.calp = 1'b1; end
                    else if (v && a == 6'h34) begin
                        if (ac) begin r.st = E_CAL; r.ret = 1'b1; r.calp = 1'b1; end
                        else r.st = E_RX;
                    end
                    else if (v && a == 6'h36) r.pend = 1'b0;
                    else if (v && a == 6'h39) r.pend = 1'b1;
                    else if (v && a == 6'h3A) r.flushp = 1'b1;
                    else if (pend && rise) r.st = E_PWRDN;
                end
                E_CAL: begin
                    if (v && a == 6'h36) r.st = E_IDLE;
                    else if (cd) r.st = ret ? E_RX : E_IDLE;
                end
                E_RX: begin
                    if (v && a == 6'h36) r.st = E_IDLE;
                    else if (ov) r.st = E_OVF;
                end
                E_OVF: begin
                    if (v && a == 6'h3A) begin r.st = E_IDLE; r.flushp = 1'b1; end
                    else if (v && a == 6'h36) r.st = E_IDLE;
                end
                default: if (fall) r.st = E_IDLE;
            endcase
        end
        if (r.st != E_IDLE) r.pend = 1'b0;
        return r;
    endfunction

    task automatic compare_bit(input string tag, input string name,
                               input logic act, input logic exp, inout logic bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual=%0b expected=%0b", tag, name, act, exp);
            bad = 1'b1;
        end
    endtask

    task automatic check_all(input string tag, input logic [2:0] st,
                             input logic cp, input logic fp, input logic rp);
        logic bad;
        bad = 1'b0;
        vectors++;
        if (state_code !== st) begin
            $display("FAIL %s state_code actual=%0d expected=%0d", tag, state_code, st);
            bad = 1'b1;
        end
        compare_bit(tag, "xosc_en", xosc_en, !(st == E_PWRDN || st == E_XOFF), bad);
        compare_bit(tag, "rx_en", rx_en, st == E_RX, bad);
        compare_bit(tag, "cal_start", cal_start, cp, bad);
        compare_bit(tag, "fifo_flush", fifo_flush, fp, bad);
        compare_bit(tag, "reg_reset", reg_reset, rp, bad);
        if (bad) miscompares++;
    endtask

    task automatic cyc(input logic v, input logic [5:0] a, input logic cd,
                       input logic ov, input logic cs, input string tag);
        model_t nx;
        strobe_valid = v; strobe_addr = a; cal_done = cd; fifo_ovf = ov; cs_n = cs;
        nx = model_next(m_st, m_pend, m_ret, m_csq, v, a, autocal_en, cd, ov, cs);
        @(posedge clk);
        @(negedge clk);
        check_all(tag, nx.st, nx.calp, nx.flushp, nx.resp);
        m_st = nx.st; m_pend = nx.pend; m_ret = nx.ret; m_csq = cs;
    endtask

    task automatic strobe(input logic [5:0] a, input string tag);
        cyc(1'b1, a, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic quiet(input logic cs, input string tag);
        cyc(1'b0, 6'h3D, 1'b0, 1'b0, cs, tag);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired actual=running expected=finished");
            miscompares++;
            vectors++;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1187));
        repeat (3) @(negedge clk);
        check_all("R1 during reset", E_IDLE, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", E_IDLE, 1'b0, 1'b0, 1'b0);
        m_csq = cs_n;

        quiet(1'b0, "R12 select low in idle");
        // R2: no-op and reserved codes
        strobe(6'h3D, "R2 nop");
        strobe(6'h31, "R2 reserved 31");
        strobe(6'h35, "R2 reserved 35");
        strobe(6'h37, "R2 reserved 37");
        strobe(6'h38, "R2 reserved 38");
        strobe(6'h3B, "R2 reserved 3B");
        strobe(6'h3C, "R2 reserved 3C");
        // R4 / R12: oscillator off and wake
        strobe(6'h32, "R4 xoff");
        strobe(6'h34, "R12 rx ignored in xoff");
        strobe(6'h3A, "R12 flush ignored in xoff");
        quiet(1'b1, "R12 rise stays xoff");
        quiet(1'b0, "R12 fall wakes to idle");
        // R5: standalone calibration
        strobe(6'h33, "R5 cal start");
        quiet(1'b0, "R5 waiting");
        cyc(1'b0, 6'h3D, 1'b1, 1'b0, 1'b0, "R5 done to idle");
        // R6 / R13 / R10 / R11
        autocal_en = 1'b0;
        strobe(6'h34, "R6 rx direct");
        strobe(6'h33, "R13 cal ignored in rx");
        strobe(6'h34, "R13 rx ignored in rx");
        strobe(6'h3A, "R10 flush ignored in rx");
        cyc(1'b0, 6'h3D, 1'b0, 1'b1, 1'b0, "R11 overflow");
        strobe(6'h34, "R11 rx ignored in ovf");
        quiet(1'b0, "R11 ovf holds");
        strobe(6'h3A, "R10 flush from ovf");
        strobe(6'h3A, "R10 flush in idle");
        // R7 / R8
        autocal_en = 1'b1;
        strobe(6'h34, "R7 rx with autocal");
        cyc(1'b0, 6'h3D, 1'b1, 1'b0, 1'b0, "R7 done to rx");
        strobe(6'h36, "R8 idle from rx");
        strobe(6'h33, "R8 cal again");
        strobe(6'h36, "R8 idle aborts cal");
        cyc(1'b0, 6'h3D, 1'b0, 1'b1, 1'b0, "R11 ovf ignored in idle");
        // R9: deferred power-down
        strobe(6'h39, "R9 pwd request");
        quiet(1'b0, "R9 still idle");
        quiet(1'b1, "R9 rise enters pwrdn");
        quiet(1'b1, "R9 holds");
        quiet(1'b0, "R12 fall wakes from pwrdn");
        strobe(6'h39, "R8 pwd request");
        strobe(6'h36, "R8 idle cancels pwd");
        quiet(1'b1, "R8 rise stays idle");
        quiet(1'b0, "R8 select low");
        // R3: register reset
        autocal_en = 1'b0;
        strobe(6'h34, "R3 into rx");
        strobe(6'h30, "R3 reset from rx");
        strobe(6'h32, "R3 into xoff");
        strobe(6'h30, "R3 reset from xoff");
        strobe(6'h39, "R3 pwd request");
        strobe(6'h30, "R3 reset cancels pwd");
        quiet(1'b1, "R3 rise stays idle");
        quiet(1'b0, "R3 select low");

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            logic       ncs, v, cd, ov;
            logic [5:0] a;
            autocal_en = ($urandom % 2) == 0;
            cd = ($urandom % 5) == 0;
            ov = ($urandom % 9) == 0;
            a  = 6'h30 + 6'($urandom % 14);
            if (($urandom % 8) == 0) begin
                ncs = !cs_n;
                v   = 1'b0;
            end else begin
                ncs = cs_n;
                v   = !cs_n && (($urandom % 5) < 2);
            end
            cyc(v, a, cd, ov, ncs, "R13 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule